// File: doc/BRIEF.md
# Autonomous Nibble-Stream Serial Transmitter

This block sends a run of 4-bit data units out of a serial clock and data pair with no processor involvement. Software first puts the opening nibble into a holding register and the remaining nibbles into a small nibble-wide RAM, starting at address 0. It then programs the address of the final RAM nibble through two size registers, and the write to the upper size register also sets the auto bit. When the processor then asks to enter standby, the block streams the holding nibble followed by RAM addresses 0, 1, 2 and so on up to the programmed last address. Each nibble goes out most significant bit first.

For the whole transfer, global interrupts are held disabled. When the last bit has left, the block does four things in the same cycle: it clears the auto bit, sets a sticky done flag, sets the interrupt enable to 1, and sends a one-cycle wake pulse that releases the processor from standby. An interrupt request that arrives during the transfer is remembered, so that on wake the processor can go to its handler. With the high-impedance option enabled, the serial lines are released while the block is idle and are driven only while bits are being shifted.

The controller has three named states. ST_IDLE waits for a standby request. The transition idle→shift is taken on a standby request with the auto bit set. ST_SHIFT moves one bit per serial clock period and fetches the next RAM nibble at each nibble boundary. The transition shift→finish is taken at the end of the last bit of the nibble at the last address. ST_FINISH is a single cycle that asserts wake, after which finish→idle is taken unconditionally.

Top module: `nibble_stream_tx`

## Requirements
- R1: The first nibble sent is the holding register (written with wr_sel=0). After it come the RAM nibbles at addresses 0x00, 0x01, … in rising order. Each nibble is sent bit 3 first and bit 0 last.
- R2: The last RAM address sent equals the 6-bit size, so a transfer carries 4*(size+2) bits. size=0x00 gives 8 bits, and size=0x3E gives 256 bits.
- R3: wr_sel=1 writes size[3:0] from wr_data[3:0]. wr_sel=2 writes size[5:4] from wr_data[1:0] and, in the same write, the auto bit from wr_data[3].
- R4: A transfer starts only on a halt_req pulse while the auto bit is set. A halt_req with the auto bit clear produces no serial clock edge, no wake pulse and no driven output.
- R5: While the auto bit is set, ie_o is 0 and ie_wr writes are ignored. Outside auto mode, ie_wr loads ie_val into ie_o. At the end of a transfer, ie_o becomes 1.
- R6: In the cycle after the last bit ends, wake_o is high for exactly one cycle. In that same cycle done_o is 1, ie_o is 1, and the auto bit is clear, so a later halt_req starts nothing.
- R7: Once set, done_o stays 1 until the next write with wr_sel=0, whatever data that write carries. Writes with other selects leave it unchanged.
- R8: A transfer does not alter the RAM. Reloading the registers and halting again sends the same RAM data again.
- R9: With HIZ_EN=1, line_oe_o is 0 while idle, 1 from the cycle after halt_req through the last bit, and 0 again in the wake cycle.
- R10: An irq_in pulse during a transfer sets irq_pend_o. It stays set through and after wake and is cleared when the next transfer starts.
- R11: The serial clock has a period of DIV system clocks: low for the first DIV/2 and high for the rest. sdata_o changes only at the end of a period, which is the falling edge. Both lines are 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 holding, 1 size low, 2 size high plus auto |
| wr_data | input | 4 | Register write data |
| halt_req | input | 1 | Processor standby request pulse |
| ie_wr | input | 1 | Interrupt-enable write strobe |
| ie_val | input | 1 | Interrupt-enable write value |
| irq_in | input | 1 | Interrupt request |
| ram_rdata | input | 4 | RAM read data for ram_addr_o |
| ram_addr_o | output | 6 | RAM read address |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |
| line_oe_o | output | 1 | Serial line drive enable (0 = high impedance) |
| done_o | output | 1 | Sticky end-of-transfer flag |
| ie_o | output | 1 | Global interrupt enable |
| wake_o | output | 1 | Standby release pulse |
| irq_pend_o | output | 1 | Interrupt seen during transfer |

## Verification
Several properties are checked on every cycle: the interrupt enable stays off whenever auto mode is set, the done flag holds until a holding-register write, the wake pulse lasts one cycle and coincides with done and enable, serial data holds steady inside a bit period, and the RAM address never runs past size plus one. Other behaviours only the bench scenarios can show: the content and order of the bit stream, its total length at the minimum and maximum sizes, the period of the serial clock, and that resending from an untouched RAM repeats the data. The same applies to the absence of any activity after a halt without auto mode, and to the life of the pending-interrupt flag across two transfers.

// File: rtl/nst_pkg.sv
package nst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FINISH = 2'd2
    } nst_state_t;

    localparam logic [1:0] SEL_HOLD    = 2'd0;
    localparam logic [1:0] SEL_SIZE_LO = 2'd1;
    localparam logic [1:0] SEL_SIZE_HI = 2'd2;
endpackage

// File: rtl/nst_regs.sv
module nst_regs
    import nst_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [NIB_W-1:0]  wr_data,
    input  logic              ie_wr,
    input  logic              ie_val,
    input  logic              xfer_end,
    output logic [NIB_W-1:0]  hold_q,
    output logic [ADDR_W-1:0] size_q,
    output logic              auto_q,
    output logic              done_q,
    output logic              ie_q
);
    localparam int HI_W = ADDR_W - NIB_W;

    logic hold_wr, lo_wr, hi_wr, auto_set;

    assign hold_wr  = wr_en && (wr_sel == SEL_HOLD);
    assign lo_wr    = wr_en && (wr_sel == SEL_SIZE_LO);
    assign hi_wr    = wr_en && (wr_sel == SEL_SIZE_HI);
    assign auto_set = hi_wr && wr_data[NIB_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            size_q <= '0;
        end else begin
            if (hold_wr) hold_q <= wr_data;
            if (lo_wr)   size_q[NIB_W-1:0] <= wr_data;
            if (hi_wr)   size_q[ADDR_W-1:NIB_W] <= wr_data[HI_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_q <= 1'b0;
            done_q <= 1'b0;
            ie_q   <= 1'b1;
        end else begin
            if (xfer_end)   auto_q <= 1'b0;
            else if (hi_wr) auto_q <= wr_data[NIB_W-1];

            if (xfer_end)     done_q <= 1'b1;
            else if (hold_wr) done_q <= 1'b0;

            if (xfer_end)                 ie_q <= 1'b1;
            else if (auto_q || auto_set)  ie_q <= 1'b0;
            else if (ie_wr)               ie_q <= ie_val;
        end
    end

    // R5
    ie_forced_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auto_q |-> !ie_q);
    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !hold_wr) |=> done_q);
endmodule

// File: rtl/nst_tick.sv
module nst_tick #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk_hi,
    output logic bit_end
);
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (!run)        cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign sclk_hi = run && (cnt >= CW'(HALF));
    assign bit_end = run && (cnt == LAST);

    // R11
    tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/nst_fsm.sv
module nst_fsm
    import nst_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_req,
    input  logic              auto_q,
    input  logic [NIB_W-1:0]  hold_q,
    input  logic [ADDR_W-1:0] size_q,
    input  logic [NIB_W-1:0]  ram_rdata,
    input  logic              bit_end,
    input  logic              irq_in,
    output logic              busy,
    output logic              xfer_end,
    output logic              wake,
    output logic              bit_out,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              irq_pend
);
    localparam int BW = (NIB_W > 2) ? $clog2(NIB_W) : 1;
    localparam logic [BW-1:0] BIT_LAST = BW'(NIB_W - 1);

    nst_state_t state, state_nx;
    logic [NIB_W-1:0] shreg;
    logic [BW-1:0]    bit_idx;
    logic             cur_last;
    logic             nib_end;

    assign nib_end  = bit_end && (bit_idx == BIT_LAST);
    assign xfer_end = (state == ST_SHIFT) && nib_end && cur_last;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (halt_req && auto_q) state_nx = ST_SHIFT;
            ST_SHIFT:  if (xfer_end)           state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_idx  <= '0;
            cur_last <= 1'b0;
            ram_addr <= '0;
            irq_pend <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (state_nx == ST_SHIFT) begin
                    shreg    <= hold_q;
                    bit_idx  <= '0;
                    cur_last <= 1'b0;
                    ram_addr <= '0;
                    irq_pend <= 1'b0;
                end
                ST_SHIFT: begin
                    if (irq_in) irq_pend <= 1'b1;
                    if (nib_end && !cur_last) begin
                        shreg    <= ram_rdata;
                        cur_last <= (ram_addr == size_q);
                        ram_addr <= ram_addr + 1'b1;
                        bit_idx  <= '0;
                    end else if (bit_end) begin
                        shreg   <= shreg << 1;
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        busy    = (state == ST_SHIFT);
        wake    = (state == ST_FINISH);
        bit_out = busy && shreg[NIB_W-1];
    end

    // R11
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_end) |=> $stable(bit_out));
    // R2
    addr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ({1'b0, ram_addr} <= ({1'b0, size_q} + 1'b1)));
    // R10
    irq_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && irq_in) |=> irq_pend);
endmodule

// File: rtl/nibble_stream_tx.sv
module nibble_stream_tx #(
    parameter int DIV    = 8,
    parameter int ADDR_W = 6,
    parameter int NIB_W  = 4,
    parameter bit HIZ_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [NIB_W-1:0]  wr_data,
    input  logic              halt_req,
    input  logic              ie_wr,
    input  logic              ie_val,
    input  logic              irq_in,
    input  logic [NIB_W-1:0]  ram_rdata,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic              sclk_o,
    output logic              sdata_o,
    output logic              line_oe_o,
    output logic              done_o,
    output logic              ie_o,
    output logic              wake_o,
    output logic              irq_pend_o
);
    logic [NIB_W-1:0]  hold_q;
    logic [ADDR_W-1:0] size_q;
    logic auto_q, busy, xfer_end, bit_end, sclk_hi;

    nst_regs #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ie_wr(ie_wr), .ie_val(ie_val),
        .xfer_end(xfer_end), .hold_q(hold_q), .size_q(size_q),
        .auto_q(auto_q), .done_q(done_o), .ie_q(ie_o)
    );

    nst_tick #(.DIV(DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy),
        .sclk_hi(sclk_hi), .bit_end(bit_end)
    );

    nst_fsm #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .auto_q(auto_q),
        .hold_q(hold_q), .size_q(size_q), .ram_rdata(ram_rdata),
        .bit_end(bit_end), .irq_in(irq_in), .busy(busy),
        .xfer_end(xfer_end), .wake(wake_o), .bit_out(sdata_o),
        .ram_addr(ram_addr_o), .irq_pend(irq_pend_o)
    );

    assign sclk_o = sclk_hi;

    generate
        if (HIZ_EN) begin : g_hiz
            assign line_oe_o = busy;
        end else begin : g_drive
            assign line_oe_o = 1'b1;
        end
    endgenerate

    // R6
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);
    // R6
    wake_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (done_o && ie_o && !auto_q));
endmodule

// File: tb/nibble_stream_tx_bench.sv
module nibble_stream_tx_bench;
    localparam int DIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, halt_req = 1'b0, ie_wr = 1'b0, ie_val = 1'b0, irq_in = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [3:0] wr_data = 4'd0;
    logic [3:0] ram_rdata;
    logic [5:0] ram_addr_o;
    logic sclk_o, sdata_o, line_oe_o, done_o, ie_o, wake_o, irq_pend_o;

    logic [3:0] ram [64];
    logic exp_q [$];
    int checks = 0, fails = 0, bits_seen = 0, gap = 0;
    logic prev_sclk = 1'b0, have_prev = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    assign ram_rdata = ram[ram_addr_o];

    nibble_stream_tx #(.DIV(DIV)) u_nibble_stream_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .halt_req(halt_req), .ie_wr(ie_wr),
        .ie_val(ie_val), .irq_in(irq_in), .ram_rdata(ram_rdata),
        .ram_addr_o(ram_addr_o), .sclk_o(sclk_o), .sdata_o(sdata_o),
        .line_oe_o(line_oe_o), .done_o(done_o), .ie_o(ie_o),
        .wake_o(wake_o), .irq_pend_o(irq_pend_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pop an expected bit at each serial clock rise
    always @(negedge clk) begin
        if (rst_n) begin
            gap++;
            if (sclk_o && !prev_sclk) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 extra bit", 1, 0);
                end else begin
                    logic e;
                    e = exp_q.pop_front();
                    chk(sdata_o == e, "R1 bit value", int'(sdata_o), int'(e));
                end
                if (have_prev) chk(gap == DIV, "R11 sclk period", gap, DIV);
                have_prev = 1'b1;
                gap = 0;
                bits_seen++;
            end
            if (!line_oe_o) have_prev = 1'b0;
            if (!line_oe_o) chk(!sclk_o && !sdata_o, "R11 idle lines", int'({sclk_o, sdata_o}), 0);
            prev_sclk = sclk_o;
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [3:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // driver: program registers and queue the expected stream
    task automatic arm(input logic [3:0] hold, input logic [5:0] size);
        wr(2'd0, hold);
        wr(2'd1, size[3:0]);
        wr(2'd2, {1'b1, 1'b0, size[5:4]});
        for (int b = 3; b >= 0; b--) exp_q.push_back(hold[b]);
        for (int a = 0; a <= int'(size); a++)
            for (int b = 3; b >= 0; b--) exp_q.push_back(ram[a][b]);
    endtask

    task automatic halt();
        @(negedge clk); halt_req = 1'b1; bits_seen = 0;
        @(negedge clk); halt_req = 1'b0;
    endtask

    task automatic wait_wake(input int nbits);
        bit seen = 1'b0;
        for (int i = 0; i < 4000 && !seen; i++) begin
            @(negedge clk);
            if (wake_o) seen = 1'b1;
        end
        chk(seen, "R6 wake seen", int'(seen), 1);
        chk(done_o && ie_o, "R6 done and ie at wake", int'({done_o, ie_o}), 3);
        chk(!line_oe_o, "R9 release after last bit", int'(line_oe_o), 0);
        chk(bits_seen == nbits, "R2 bit count", bits_seen, nbits);
        chk(exp_q.size() == 0, "R1 stream complete", exp_q.size(), 0);
        @(negedge clk);
        chk(!wake_o, "R6 wake one cycle", int'(wake_o), 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) ram[i] = 4'((i * 7 + 3) ^ (i >> 2));
        repeat (3) @(negedge clk);
        chk(!done_o && ie_o && !wake_o && !line_oe_o && !irq_pend_o,
            "R9 reset state", int'({done_o, ie_o, wake_o, line_oe_o, irq_pend_o}), 8);
        rst_n = 1'b1;

        // R4: halt without auto does nothing
        halt();
        repeat (20) @(negedge clk);
        chk(bits_seen == 0 && !line_oe_o && !done_o, "R4 no start without auto", bits_seen, 0);

        // R5: ie writable outside auto mode
        @(negedge clk); ie_wr = 1'b1; ie_val = 1'b0;
        @(negedge clk); ie_wr = 1'b0;
        chk(!ie_o, "R5 ie write outside auto", int'(ie_o), 0);

        // minimum transfer, R2 size 0
        arm(4'hA, 6'h00);
        chk(!ie_o, "R5 ie off in auto", int'(ie_o), 0);
        halt();
        chk(line_oe_o, "R9 drive during transfer", int'(line_oe_o), 1);
        wait_wake(8);

        // R6/R7: auto cleared, done sticky across other writes
        halt();
        repeat (20) @(negedge clk);
        chk(bits_seen == 0, "R6 auto cleared after transfer", bits_seen, 0);
        wr(2'd1, 4'h3);
        chk(done_o, "R7 done held over size write", int'(done_o), 1);
        wr(2'd0, 4'h0);
        chk(!done_o, "R7 done cleared by hold write", int'(done_o), 0);

        // R3 split size, R5 ie write ignored, R10 irq pending
        arm(4'h5, 6'h13);
        halt();
        repeat (9) @(negedge clk);
        ie_wr = 1'b1; ie_val = 1'b1; irq_in = 1'b1;
        @(negedge clk); ie_wr = 1'b0; irq_in = 1'b0;
        chk(!ie_o, "R5 ie write ignored in auto", int'(ie_o), 0);
        chk(irq_pend_o, "R10 irq latched", int'(irq_pend_o), 1);
        wait_wake(4 * (6'h13 + 2));
        chk(irq_pend_o, "R10 pending after wake", int'(irq_pend_o), 1);

        // R8 resend with unchanged RAM; R10 cleared on new start
        wr(2'd0, 4'h5);
        arm(4'h5, 6'h13);
        halt();
        chk(!irq_pend_o, "R10 cleared at next start", int'(irq_pend_o), 0);
        wait_wake(4 * (6'h13 + 2));
        chk(ram_addr_o == 6'h14, "R8 resend reached same last address", ram_addr_o, 6'h14);

        // maximum transfer, R2 size 0x3E
        wr(2'd0, 4'hF);
        arm(4'hC, 6'h3E);
        halt();
        wait_wake(256);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule